// File: doc/BRIEF.md
# Per-Target Urgent Interrupt Selector

This block picks, for each of several target processors, the most urgent shared interrupt that is ready to be delivered. It keeps the pending and active state of every shared interrupt line. It takes per-line enable, group, priority and 64-bit routing values as plain inputs, along with a small control register of group enables. A sequential scanner visits one interrupt ID per clock. It keeps a running best candidate for every target and publishes all targets' results together at the end of each pass.

Each target sees its result as a valid/ack stream. A result with `sel_valid_o` high is held unchanged until that target acknowledges it or the selected interrupt stops being eligible; there is no other back-pressure. An acknowledge moves the interrupt from pending to active. A later deactivate request clears the active state. Routing is resolved per interrupt, in one of two ways. Affinity mode sends the interrupt to the target whose affinity word matches. Participation mode sends it to the first willing target in index order.

Top module: `irq_urgent_sel`

## Requirements
- R1: An interrupt is a candidate only when it is pending, enabled, not active and its group is enabled. Group codes are 0 = group 0 (control bit 0), 1 = non-secure group 1 (control bit 1), 2 = secure group 1 (control bit 2), and 3 = never enabled.
- R2: Among a target's candidates, the numerically lowest priority value wins. On equal priority the lowest interrupt ID wins.
- R3: With routing bit 31 clear, the target is the one whose `tgt_aff_i` word equals {route[39:32], route[23:16], route[15:8], route[7:0]}. If several targets match, the lowest index is used.
- R4: With routing bit 31 set, the target is the lowest-index target whose `tgt_join_i` bit is set and whose `tgt_grp_acc_i` bit for the interrupt's group code is set.
- R5: A candidate with no resolvable target stays pending and is presented to no target.
- R6: A target with no selection reports valid 0, priority 0xFF, ID 0 and group 0. An interrupt with priority 0xFF is never presented.
- R7: `sel_valid_o` of a target is high exactly when its reported priority is below 0xFF.
- R8: Acknowledge has the following effects and limits.
  - An acknowledge while valid clears the selected interrupt's pending bit, sets its active bit, and makes the target idle in the next cycle.
  - An acknowledge while not valid has no effect.
  - Deactivate clears only the active bit of the given ID.
- R9: The control register uses bit 0 for group 0 enable, bit 1 for non-secure group 1, bit 2 for secure group 1 and bit 3 for security disable. Reads of `ctl_q_o` use the same layout. The register resets to 0. A write with bit 3 set stores bit 2 as 0.
- R10: IDs below FIRST_ID (32) ignore set-pending requests and are never selected.
- R11: The scan visits one ID per clock. A set-pending, acknowledge, deactivate or control write restarts the pass. Results are published together exactly NUM_IRQ-FIRST_ID cycles after the restarting edge. Changes to enable, group, priority or routing are reflected within two pass lengths.
- R12: When a target's published selection loses eligibility, its result becomes idle at the next edge and a full rescan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data {sec_dis, en_g1s, en_g1ns, en_g0} |
| ctl_q_o | output | 4 | Control register contents, same layout |
| set_pend_i | input | NUM_IRQ | One-cycle set-pending request per ID |
| enable_i | input | NUM_IRQ | Per-ID enable |
| group_i | input | 2*NUM_IRQ | Per-ID group code |
| prio_i | input | PRIO_W*NUM_IRQ | Per-ID priority, lower is more urgent |
| route_i | input | 64*NUM_IRQ | Per-ID routing word |
| tgt_aff_i | input | 32*NUM_TGT | Affinity word of each target |
| tgt_join_i | input | NUM_TGT | Target takes part in participation routing |
| tgt_grp_acc_i | input | 3*NUM_TGT | Groups each target accepts in participation routing |
| ack_i | input | NUM_TGT | Per-target acknowledge (ready) |
| deact_valid_i | input | 1 | Deactivate request |
| deact_id_i | input | IDW | ID to deactivate |
| sel_valid_o | output | NUM_TGT | Per-target selection valid |
| sel_id_o | output | IDW*NUM_TGT | Selected ID per target |
| sel_prio_o | output | PRIO_W*NUM_TGT | Selected priority per target, 0xFF when idle |
| sel_grp_o | output | 2*NUM_TGT | Selected group code per target |
| pend_o | output | NUM_IRQ | Pending state |
| act_o | output | NUM_IRQ | Active state |

## Verification
The bound checker watches every cycle for several properties. The valid flag must agree with the idle priority. An acknowledged selection must move to active and drop the target to idle, and a deactivate must clear the active bit. Low IDs must never turn pending, a valid selection must never name an unscanned ID, and the security-disable bit must never coexist with the secure group 1 enable. Only the bench's scenarios can show the rest. These are which interrupt wins under mixed priorities, ties, groups and both routing modes; that unroutable or 0xFF-priority interrupts stay unpresented; the exact publish latency after a restart; and the drop to idle when a selection loses its enable.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  // Interrupt group codes
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1NS = 2'd1,
    GRP_G1S  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int ROUTE_W    = 64;
  localparam int AFF_W      = 32;
  localparam int CTL_W      = 4;
  localparam int ROUTE_MODE = 31;

  // Group enabled under the given control enables
  function automatic logic grp_on(logic [1:0] g, logic [2:0] en);
    case (g)
      GRP_G0:   return en[0];
      GRP_G1NS: return en[1];
      GRP_G1S:  return en[2];
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq_sel_ctl.sv
module irq_sel_ctl
  import irq_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] q_o
);
  logic [CTL_W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (we_i) begin
      // security disable wipes the secure group 1 enable
      q_q <= {wdata_i[3], wdata_i[2] & ~wdata_i[3], wdata_i[1:0]};
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_sel_route.sv
module irq_sel_route
  import irq_sel_pkg::*;
#(
  parameter int NUM_TGT = 2
) (
  input  logic [ROUTE_W-1:0]       route_i,
  input  logic [1:0]               grp_i,
  input  logic [AFF_W*NUM_TGT-1:0] tgt_aff_i,
  input  logic [NUM_TGT-1:0]       tgt_join_i,
  input  logic [3*NUM_TGT-1:0]     tgt_grp_acc_i,
  output logic [NUM_TGT-1:0]       hit_o
);
  logic [AFF_W-1:0]   aff_key;
  logic [NUM_TGT-1:0] want;
  logic               unused_route;

  assign aff_key      = {route_i[39:32], route_i[23:0]};
  assign unused_route = ^{route_i[63:40], route_i[30:24]};

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic [2:0] acc;
    logic       join_ok;
    assign acc     = tgt_grp_acc_i[t*3 +: 3];
    assign join_ok = tgt_join_i[t] && grp_on(grp_i, acc);
    assign want[t] = route_i[ROUTE_MODE] ? join_ok
                                         : (aff_key == tgt_aff_i[t*AFF_W +: AFF_W]);
  end

  // lowest-index target wins
  assign hit_o = want & ~(want - 1'b1);
endmodule

// File: rtl/irq_urgent_sel.sv
module irq_urgent_sel
  import irq_sel_pkg::*;
#(
  parameter  int NUM_IRQ  = 64,
  parameter  int NUM_TGT  = 2,
  parameter  int FIRST_ID = 32,
  parameter  int PRIO_W   = 8,
  localparam int IDW      = $clog2(NUM_IRQ)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ctl_we_i,
  input  logic [CTL_W-1:0]           ctl_wdata_i,
  output logic [CTL_W-1:0]           ctl_q_o,
  input  logic [NUM_IRQ-1:0]         set_pend_i,
  input  logic [NUM_IRQ-1:0]         enable_i,
  input  logic [2*NUM_IRQ-1:0]       group_i,
  input  logic [PRIO_W*NUM_IRQ-1:0]  prio_i,
  input  logic [ROUTE_W*NUM_IRQ-1:0] route_i,
  input  logic [AFF_W*NUM_TGT-1:0]   tgt_aff_i,
  input  logic [NUM_TGT-1:0]         tgt_join_i,
  input  logic [3*NUM_TGT-1:0]       tgt_grp_acc_i,
  input  logic [NUM_TGT-1:0]         ack_i,
  input  logic                       deact_valid_i,
  input  logic [IDW-1:0]             deact_id_i,
  output logic [NUM_TGT-1:0]         sel_valid_o,
  output logic [IDW*NUM_TGT-1:0]     sel_id_o,
  output logic [PRIO_W*NUM_TGT-1:0]  sel_prio_o,
  output logic [2*NUM_TGT-1:0]       sel_grp_o,
  output logic [NUM_IRQ-1:0]         pend_o,
  output logic [NUM_IRQ-1:0]         act_o
);
  localparam logic [IDW-1:0]    ID_FIRST = IDW'(FIRST_ID);
  localparam logic [IDW-1:0]    ID_LAST  = IDW'(NUM_IRQ - 1);
  localparam logic [PRIO_W-1:0] P_IDLE   = '1;

  logic [NUM_IRQ-1:0] pend_q, act_q, scan_mask, ack_clr, deact_vec;
  logic [CTL_W-1:0]   ctl_q;
  logic [IDW-1:0]     idx_q;
  logic               last, restart;

  irq_sel_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctl_we_i),
    .wdata_i(ctl_wdata_i), .q_o(ctl_q)
  );
  assign ctl_q_o = ctl_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    assign scan_mask[i] = (i >= FIRST_ID);
  end

  // candidate at the scan index
  logic [PRIO_W-1:0]  prio_cur;
  logic [1:0]         grp_cur;
  logic               cand_cur;
  logic [NUM_TGT-1:0] hit_cur;

  assign prio_cur = prio_i[int'(idx_q)*PRIO_W +: PRIO_W];
  assign grp_cur  = group_i[int'(idx_q)*2 +: 2];
  assign cand_cur = pend_q[idx_q] & enable_i[idx_q] & ~act_q[idx_q]
                  & grp_on(grp_cur, ctl_q[2:0]);

  irq_sel_route #(.NUM_TGT(NUM_TGT)) u_rt_scan (
    .route_i(route_i[int'(idx_q)*ROUTE_W +: ROUTE_W]), .grp_i(grp_cur),
    .tgt_aff_i(tgt_aff_i), .tgt_join_i(tgt_join_i),
    .tgt_grp_acc_i(tgt_grp_acc_i), .hit_o(hit_cur)
  );

  // per-target running best and published result
  logic [PRIO_W-1:0]  best_prio_q [NUM_TGT];
  logic [IDW-1:0]     best_id_q   [NUM_TGT];
  logic [1:0]         best_grp_q  [NUM_TGT];
  logic [NUM_TGT-1:0] best_vld_q;
  logic [PRIO_W-1:0]  res_prio_q  [NUM_TGT];
  logic [IDW-1:0]     res_id_q    [NUM_TGT];
  logic [1:0]         res_grp_q   [NUM_TGT];
  logic [NUM_TGT-1:0] res_vld_q, ack_eff, stale, take;

  assign ack_eff = ack_i & res_vld_q;
  assign last    = (idx_q == ID_LAST);
  assign restart = (|(set_pend_i & scan_mask)) | (|ack_eff) | deact_valid_i
                 | ctl_we_i | (|stale);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic [NUM_TGT-1:0] hit_res;
    logic [1:0]         grp_res;
    logic               elig_res;

    assign grp_res = group_i[int'(res_id_q[t])*2 +: 2];
    irq_sel_route #(.NUM_TGT(NUM_TGT)) u_rt_res (
      .route_i(route_i[int'(res_id_q[t])*ROUTE_W +: ROUTE_W]), .grp_i(grp_res),
      .tgt_aff_i(tgt_aff_i), .tgt_join_i(tgt_join_i),
      .tgt_grp_acc_i(tgt_grp_acc_i), .hit_o(hit_res)
    );
    assign elig_res = pend_q[res_id_q[t]] & enable_i[res_id_q[t]]
                    & ~act_q[res_id_q[t]] & grp_on(grp_res, ctl_q[2:0]) & hit_res[t];
    assign stale[t] = res_vld_q[t] & ~elig_res;
    assign take[t]  = cand_cur & hit_cur[t] & (prio_cur < best_prio_q[t]);

    always_ff @(posedge clk_i) begin
      if (!rst_ni || restart || last) begin
        best_prio_q[t] <= P_IDLE;
        best_id_q[t]   <= '0;
        best_grp_q[t]  <= '0;
        best_vld_q[t]  <= 1'b0;
      end else if (take[t]) begin
        best_prio_q[t] <= prio_cur;
        best_id_q[t]   <= idx_q;
        best_grp_q[t]  <= grp_cur;
        best_vld_q[t]  <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni || ack_eff[t] || stale[t]) begin
        res_prio_q[t] <= P_IDLE;
        res_id_q[t]   <= '0;
        res_grp_q[t]  <= '0;
        res_vld_q[t]  <= 1'b0;
      end else if (last && !restart) begin
        res_prio_q[t] <= take[t] ? prio_cur : best_prio_q[t];
        res_id_q[t]   <= take[t] ? idx_q    : best_id_q[t];
        res_grp_q[t]  <= take[t] ? grp_cur  : best_grp_q[t];
        res_vld_q[t]  <= take[t] | best_vld_q[t];
      end
    end

    assign sel_valid_o[t]                  = res_vld_q[t];
    assign sel_id_o[t*IDW +: IDW]          = res_id_q[t];
    assign sel_prio_o[t*PRIO_W +: PRIO_W]  = res_prio_q[t];
    assign sel_grp_o[t*2 +: 2]             = res_grp_q[t];
  end

  // scan index
  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart || last) idx_q <= ID_FIRST;
    else                            idx_q <= idx_q + 1'b1;
  end

  // pending / active state
  always_comb begin
    ack_clr   = '0;
    deact_vec = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (ack_eff[t]) ack_clr[res_id_q[t]] = 1'b1;
    end
    if (deact_valid_i && (int'(deact_id_i) < NUM_IRQ)) deact_vec[deact_id_i] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_clr) | (set_pend_i & scan_mask);
      act_q  <= (act_q & ~deact_vec) | ack_clr;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_urgent_sel_chk.sv
module irq_urgent_sel_chk #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_TGT  = 2,
  parameter int FIRST_ID = 32,
  parameter int PRIO_W   = 8,
  parameter int IDW      = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [3:0]                ctl_q_o,
  input logic [NUM_IRQ-1:0]        set_pend_i,
  input logic [NUM_TGT-1:0]        ack_i,
  input logic                      deact_valid_i,
  input logic [IDW-1:0]            deact_id_i,
  input logic [NUM_TGT-1:0]        sel_valid_o,
  input logic [IDW*NUM_TGT-1:0]    sel_id_o,
  input logic [PRIO_W*NUM_TGT-1:0] sel_prio_o,
  input logic [NUM_IRQ-1:0]        pend_o,
  input logic [NUM_IRQ-1:0]        act_o
);
  // R9
  ds_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q_o[3] |-> !ctl_q_o[2]);

  // R10
  low_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[FIRST_ID-1:0] == '0);

  // R8 deactivate
  deact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_valid_i && ack_i == '0 && int'(deact_id_i) < NUM_IRQ)
    |=> !act_o[$past(deact_id_i)]);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
    // R7
    vld_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o[t] == (sel_prio_o[t*PRIO_W +: PRIO_W] != '1));

    // R10
    id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o[t] |-> (int'(sel_id_o[t*IDW +: IDW]) >= FIRST_ID));

    // R8 acknowledge
    ack_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[t] && sel_valid_o[t] && set_pend_i == '0)
      |=> (!sel_valid_o[t] && act_o[$past(sel_id_o[t*IDW +: IDW])]
           && !pend_o[$past(sel_id_o[t*IDW +: IDW])]));
  end
endmodule

bind irq_urgent_sel irq_urgent_sel_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_TGT(NUM_TGT), .FIRST_ID(FIRST_ID),
  .PRIO_W(PRIO_W), .IDW(IDW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_q_o(ctl_q_o), .set_pend_i(set_pend_i),
  .ack_i(ack_i), .deact_valid_i(deact_valid_i), .deact_id_i(deact_id_i),
  .sel_valid_o(sel_valid_o), .sel_id_o(sel_id_o), .sel_prio_o(sel_prio_o),
  .pend_o(pend_o), .act_o(act_o)
);

// File: tb/sim_irq_urgent_sel.sv
module sim_irq_urgent_sel;
  localparam int N = 40, T = 3, F = 32, PW = 8, IDW = 6, L = N - F;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ctl_we = 0;
  logic [3:0]    ctl_wd = 0, ctl_q;
  logic [N-1:0]  set_pend = '0, en = '0, pend, act;
  logic [2*N-1:0]  grp = '0;
  logic [PW*N-1:0] prio = '0;
  logic [64*N-1:0] route = '0;
  logic [32*T-1:0] aff = '0;
  logic [T-1:0]    tjoin = '0, ack = '0, sv;
  logic [3*T-1:0]  acc = '0;
  logic            dv = 0;
  logic [IDW-1:0]  did = '0;
  logic [IDW*T-1:0] sid;
  logic [PW*T-1:0]  sp;
  logic [2*T-1:0]   sg;

  logic [N-1:0] m_pend = '0, m_act = '0;
  logic [3:0]   m_ctl = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_urgent_sel #(.NUM_IRQ(N), .NUM_TGT(T), .FIRST_ID(F), .PRIO_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .ctl_q_o(ctl_q), .set_pend_i(set_pend), .enable_i(en), .group_i(grp),
    .prio_i(prio), .route_i(route), .tgt_aff_i(aff), .tgt_join_i(tjoin),
    .tgt_grp_acc_i(acc), .ack_i(ack), .deact_valid_i(dv), .deact_id_i(did),
    .sel_valid_o(sv), .sel_id_o(sid), .sel_prio_o(sp), .sel_grp_o(sg),
    .pend_o(pend), .act_o(act)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] a,
                     input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tgt_of(input int i);
    logic [63:0] r = route[i*64 +: 64];
    int g = int'(grp[i*2 +: 2]);
    if (!r[31]) begin
      for (int t = 0; t < T; t++)
        if ({r[39:32], r[23:0]} == aff[t*32 +: 32]) return t;
    end else begin
      for (int t = 0; t < T; t++)
        if (tjoin[t] && g < 3 && acc[t*3 + g]) return t;
    end
    return -1;
  endfunction

  function automatic bit grp_en(input int g);
    return g < 3 && m_ctl[g];
  endfunction

  // R1 R2 R3 R4 R5 R6 model compare
  task automatic expect_all(input string tag);
    for (int t = 0; t < T; t++) begin
      int best = 255, bid = 0, bg = 0;
      for (int i = F; i < N; i++) begin
        int p = int'(prio[i*8 +: 8]);
        if (m_pend[i] && en[i] && !m_act[i] && grp_en(int'(grp[i*2 +: 2]))
            && tgt_of(i) == t && p < best) begin
          best = p; bid = i; bg = int'(grp[i*2 +: 2]);
        end
      end
      chk(sv[t] == (best < 255), {tag, " R1 R7 valid"}, sv[t], best < 255);
      chk(sp[t*8 +: 8] == 8'(best), {tag, " R2 R6 prio"}, sp[t*8 +: 8], best);
      chk(sid[t*IDW +: IDW] == IDW'(bid), {tag, " R2 R3 R4 id"}, sid[t*IDW +: IDW], bid);
      chk(sg[t*2 +: 2] == 2'(bg), {tag, " R1 grp"}, sg[t*2 +: 2], bg);
    end
    chk(pend == m_pend, {tag, " R5 R8 pend"}, pend, m_pend);
    chk(act == m_act, {tag, " R8 act"}, act, m_act);
  endtask

  task automatic settle;
    step(3 * L + 4);
  endtask

  task automatic pulse_pend(input logic [N-1:0] v);
    set_pend = v;
    step(1);
    set_pend = '0;
    for (int i = F; i < N; i++) if (v[i]) m_pend[i] = 1'b1;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1; ctl_wd = v;
    step(1);
    ctl_we = 0;
    m_ctl = {v[3], v[2] & ~v[3], v[1:0]};
  endtask

  task automatic do_ack(input int t);
    int id = int'(sid[t*IDW +: IDW]);
    bit was = sv[t];
    ack[t] = 1'b1;
    step(1);
    ack = '0;
    if (was) begin
      m_pend[id] = 1'b0; m_act[id] = 1'b1;
      chk(pend[id] == 0 && act[id] == 1, "R8 ack moves to active", {pend[id], act[id]}, 2'b01);
      chk(sv[t] == 0, "R8 idle after ack", sv[t], 0);
    end else begin
      chk(pend == m_pend && act == m_act, "R8 ack ignored when idle", {pend, act}, {m_pend, m_act});
    end
  endtask

  task automatic do_deact(input int id);
    dv = 1; did = IDW'(id);
    step(1);
    dv = 0;
    m_act[id] = 1'b0;
    chk(act == m_act && pend == m_pend, "R8 deactivate", {pend, act}, {m_pend, m_act});
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // reset state R6 R9
    chk(ctl_q == 0, "R9 reset ctl", ctl_q, 0);
    chk(sv == 0, "R6 reset valid", sv, 0);
    chk(sp == '1, "R6 reset prio", sp, '1);
    chk(pend == 0 && act == 0, "R8 reset state", {pend, act}, 0);

    wr_ctl(4'b1111);
    chk(ctl_q == 4'b1011, "R9 security disable clears g1s", ctl_q, 4'b1011);
    wr_ctl(4'b0111);
    chk(ctl_q == 4'b0111, "R9 plain write", ctl_q, 4'b0111);

    for (int t = 0; t < T; t++) aff[t*32 +: 32] = 32'(t);
    en = '1;
    for (int i = 0; i < N; i++) begin
      grp[i*2 +: 2] = 2'd1;
      prio[i*8 +: 8] = 8'h20;
      route[i*64 +: 64] = 64'h99;
    end
    route[34*64 +: 64] = 64'h0;
    step(2);

    // R11 publish latency
    pulse_pend(N'(1) << 34);
    step(L - 1);
    chk(sv[0] == 0, "R11 not before end of pass", sv[0], 0);
    step(1);
    chk(sv[0] == 1 && sid[0 +: IDW] == 34, "R11 published at end of pass", {sv[0], sid[0 +: IDW]}, {1'b1, 6'd34});
    do_ack(0);
    do_deact(34);

    // R10 low id ignored
    pulse_pend(N'(1) << 5);
    settle();
    chk(pend[5] == 0, "R10 low id not pending", pend[5], 0);
    expect_all("R10");

    // R2 tie on priority
    route[35*64 +: 64] = 64'h1; route[33*64 +: 64] = 64'h1;
    pulse_pend((N'(1) << 35) | (N'(1) << 33));
    settle();
    chk(sid[IDW +: IDW] == 33, "R2 tie lowest id", sid[IDW +: IDW], 33);
    expect_all("R2 tie");

    // R6 priority 0xFF, R5 unroutable
    route[36*64 +: 64] = 64'h2; prio[36*8 +: 8] = 8'hFF;
    route[37*64 +: 64] = 64'h1_0000_0002;
    pulse_pend((N'(1) << 36) | (N'(1) << 37));
    settle();
    chk(sv[2] == 0, "R6 R5 nothing presented to target 2", sv[2], 0);
    chk(pend[36] && pend[37], "R5 stays pending", {pend[36], pend[37]}, 2'b11);

    // R12 loss of eligibility
    en[33] = 1'b0;
    step(1);
    chk(sv[1] == 0, "R12 idle after enable drop", sv[1], 0);
    settle();
    chk(sid[IDW +: IDW] == 35, "R12 rescan finds next", sid[IDW +: IDW], 35);
    expect_all("R12");

    // randomized sweeps R1 R2 R3 R4 R8 R11
    for (int it = 0; it < 300; it++) begin
      for (int i = F; i < N; i++) begin
        logic [63:0] r = '0;
        en[i] = ($urandom_range(3) != 0);
        grp[i*2 +: 2] = 2'($urandom_range(3));
        prio[i*8 +: 8] = ($urandom_range(7) == 0) ? 8'hFF : 8'($urandom_range(3) * 16);
        r[7:0] = 8'($urandom_range(3));
        r[31] = 1'($urandom_range(1));
        r[39:32] = ($urandom_range(7) == 0) ? 8'h1 : 8'h0;
        route[i*64 +: 64] = r;
      end
      tjoin = T'($urandom_range((1 << T) - 1));
      acc = (3*T)'($urandom_range((1 << (3*T)) - 1));
      if (it % 4 == 0) wr_ctl(4'($urandom_range(15)));
      pulse_pend(N'({$urandom, $urandom}));
      settle();
      expect_all("sweep");
      do_ack(it % T);
      settle();
      expect_all("after ack");
      for (int i = F; i < N; i++) begin
        if (m_act[i] && $urandom_range(1) == 1) begin
          do_deact(i);
          break;
        end
      end
      settle();
      expect_all("after deact");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule